// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one destination address at a time, whether a received Ethernet frame is kept or dropped. An upstream parser presents the 48-bit destination address with a one-cycle strobe. One clock later the filter returns an accept flag and a code that says which rule admitted the frame.

Four rules can admit a frame. The first is a set of exact-match address slots, each with its own enable. A slot holding the all-ones address serves as the broadcast rule. The third rule is a 64-bin multicast hash table indexed by a field of the address CRC-32. The last is a promiscuous mode that admits everything.

Software programs the rules through a simple 16-bit register write port. A write takes effect at the clock edge that captures it. A lookup presented in that same cycle still sees the old settings.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `res_valid`, `res_accept` and `res_type` are 0, every slot is disabled and promiscuous and hash modes are off, so any lookup gives type NONE.
- R2: A lookup strobed on `da_valid` at clock edge N produces `res_valid`=1 after edge N+1 for exactly one cycle; without a strobe `res_valid` is 0.
- R3: The hash index is computed as follows. A CRC register starts at 0xFFFFFFFF and takes the 48 address bits LSB-first, starting with `da_addr[0]`. The reflected polynomial 0xEDB88320 is used and there is no final complement. The 32-bit result is then bit-reversed, and bits 28..23 of the reversed value form the index, with bit 28 as the MSB. Table word index[5:4], written at register address 1+index[5:4], bit index[3:0], admits the frame as type HASH when that bit is 1.
- R4: The hash rule applies only while control register (address 0) bit 1 is set; with it clear, table contents have no effect.
- R5: The hash rule applies only to multicast addresses, meaning those with `da_addr[0]`=1 that are not all ones. Unicast and broadcast addresses never give HASH.
- R6: Slot s holds its address in three words at register addresses 8+3s (bits 15:0 of the address, byte1:byte0), 9+3s (bits 31:16) and 10+3s (bits 47:32). Byte0 is the first byte on the wire and maps to `da_addr[7:0]`. An enabled slot whose stored value equals `da_addr` yields type EXACT.
- R7: Slot s is enabled by control register bit 8+s. A disabled slot never matches.
- R8: An all-ones address that equals an enabled slot yields type BCAST; with no such slot it gives NONE.
- R9: Control register bit 0 (promiscuous) makes every lookup yield type PROMISC.
- R10: The type codes are NONE=0, EXACT=1, BCAST=2, HASH=3 and PROMISC=4. When several rules hold, PROMISC wins over HASH, HASH over BCAST and BCAST over EXACT.
- R11: A configuration write in the same cycle as a lookup does not affect that lookup; it applies from the next one.
- R12: `res_accept` is 1 exactly when `res_valid` is 1 and `res_type` is not NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte0 in bits 7:0 |
| res_valid | output | 1 | Decision valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_type | output | 3 | Rule that admitted the frame |

## Verification
The bench builds the filter with two exact-match slots and the default four-word hash table. At that size every slot-enable combination and every one of the 64 hash bins can be visited. For each bin the bench loads a table with only that bin set and sends sixteen multicast addresses. Each address must hit exactly when the bench's own CRC arithmetic lands on that bin. Flipping every single address bit against a programmed slot covers the exact-compare width and the word layout of the slots.

// File: rtl/raf_pkg.sv
package raf_pkg;
   localparam int unsigned ADDR_BITS = 48;
   localparam int unsigned WORD_W    = 16;
   localparam int unsigned SLOT_WDS  = ADDR_BITS / WORD_W;
   localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;

   typedef enum logic [2:0] {
      MT_NONE    = 3'd0,
      MT_EXACT   = 3'd1,
      MT_BCAST   = 3'd2,
      MT_HASH    = 3'd3,
      MT_PROMISC = 3'd4
   } match_t;
endpackage

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs
   import raf_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned TBL_WORDS = 4,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned SLOT_BASE = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [WORD_W-1:0]               wdata,
   output logic                            promisc,
   output logic                            hash_en,
   output logic [NUM_SLOTS-1:0]            slot_en,
   output logic [TBL_WORDS*WORD_W-1:0]     hash_tbl,
   output logic [NUM_SLOTS*ADDR_BITS-1:0]  slot_addr
);
   localparam int unsigned EN_LSB = 8;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         promisc <= 1'b0;
         hash_en <= 1'b0;
         slot_en <= '0;
      end else if (we && addr == '0) begin
         promisc <= wdata[0];
         hash_en <= wdata[1];
         slot_en <= wdata[EN_LSB +: NUM_SLOTS];
      end
   end

   for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n)
            hash_tbl[w*WORD_W +: WORD_W] <= '0;
         else if (we && addr == ADDR_W'(1 + w))
            hash_tbl[w*WORD_W +: WORD_W] <= wdata;
      end
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar k = 0; k < SLOT_WDS; k++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_addr[s*ADDR_BITS + k*WORD_W +: WORD_W] <= '0;
            else if (we && addr == ADDR_W'(SLOT_BASE + SLOT_WDS*s + k))
               slot_addr[s*ADDR_BITS + k*WORD_W +: WORD_W] <= wdata;
         end
      end
   end
endmodule

// File: rtl/raf_hash_index.sv
module raf_hash_index
   import raf_pkg::*;
#(
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned HASH_TOP = 28
) (
   input  logic [ADDR_BITS-1:0] addr,
   output logic [IDX_W-1:0]     idx
);
   function automatic logic [31:0] crc_rev(input logic [ADDR_BITS-1:0] d);
      logic [31:0] c;
      logic [31:0] r;
      logic        fb;
      c = '1;
      for (int i = 0; i < ADDR_BITS; i++) begin
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ CRC_POLY;
      end
      for (int k = 0; k < 32; k++) r[k] = c[31-k];
      return r;
   endfunction

   logic [31:0] rev;
   assign rev = crc_rev(addr);
   assign idx = rev[HASH_TOP -: IDX_W];
endmodule

// File: rtl/raf_exact_match.sv
module raf_exact_match
   import raf_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4
) (
   input  logic [ADDR_BITS-1:0]           addr,
   input  logic [NUM_SLOTS-1:0]           slot_en,
   input  logic [NUM_SLOTS*ADDR_BITS-1:0] slot_addr,
   output logic                           any_hit
);
   logic [NUM_SLOTS-1:0] hit;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
      assign hit[s] = slot_en[s] && (slot_addr[s*ADDR_BITS +: ADDR_BITS] == addr);
   end

   assign any_hit = |hit;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import raf_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned TBL_WORDS = 4,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned HASH_TOP  = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [15:0]       cfg_wdata,
   input  logic              da_valid,
   input  logic [47:0]       da_addr,
   output logic              res_valid,
   output logic              res_accept,
   output logic [2:0]        res_type
);
   localparam int unsigned SLOT_BASE = 8;
   localparam int unsigned TBL_BITS  = TBL_WORDS * WORD_W;
   localparam int unsigned IDX_W     = $clog2(TBL_BITS);

   if (NUM_SLOTS < 1 || NUM_SLOTS > 8) begin : g_bad_slots
      $error("NUM_SLOTS must be 1..8");
   end
   if ((1 << IDX_W) != TBL_BITS) begin : g_bad_tbl
      $error("table bit count must be a power of two");
   end
   if (1 + TBL_WORDS > SLOT_BASE) begin : g_bad_map
      $error("hash words overlap slot registers");
   end
   if (SLOT_BASE + SLOT_WDS*NUM_SLOTS > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too small for register map");
   end
   if (HASH_TOP > 31 || HASH_TOP + 1 < IDX_W) begin : g_bad_top
      $error("HASH_TOP out of range");
   end

   logic                           promisc, hash_en, exact_hit;
   logic [NUM_SLOTS-1:0]           slot_en;
   logic [TBL_BITS-1:0]            hash_tbl;
   logic [NUM_SLOTS*ADDR_BITS-1:0] slot_addr;
   logic [IDX_W-1:0]               idx;

   raf_cfg_regs #(
      .NUM_SLOTS(NUM_SLOTS), .TBL_WORDS(TBL_WORDS),
      .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .promisc(promisc), .hash_en(hash_en), .slot_en(slot_en),
      .hash_tbl(hash_tbl), .slot_addr(slot_addr)
   );

   raf_hash_index #(.IDX_W(IDX_W), .HASH_TOP(HASH_TOP)) i_hash (
      .addr(da_addr), .idx(idx)
   );

   raf_exact_match #(.NUM_SLOTS(NUM_SLOTS)) i_exact (
      .addr(da_addr), .slot_en(slot_en), .slot_addr(slot_addr), .any_hit(exact_hit)
   );

   logic   is_bcast, is_mcast, hash_hit;
   match_t kind;

   assign is_bcast = &da_addr;
   assign is_mcast = da_addr[0] && !is_bcast;
   assign hash_hit = hash_en && is_mcast && hash_tbl[idx];

   always_comb begin
      if (promisc)                    kind = MT_PROMISC;
      else if (hash_hit)              kind = MT_HASH;
      else if (exact_hit && is_bcast) kind = MT_BCAST;
      else if (exact_hit)             kind = MT_EXACT;
      else                            kind = MT_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_type   <= MT_NONE;
      end else begin
         res_valid  <= da_valid;
         res_accept <= da_valid && (kind != MT_NONE);
         res_type   <= da_valid ? kind : MT_NONE;
      end
   end
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [15:0]       cfg_wdata,
   input logic              da_valid,
   input logic [47:0]       da_addr,
   input logic              res_valid,
   input logic              res_accept,
   input logic [2:0]        res_type
);
   logic promisc_seen;
   always_ff @(posedge clk) begin
      if (!rst_n) promisc_seen <= 1'b0;
      else if (cfg_we && cfg_addr == '0) promisc_seen <= cfg_wdata[0];
   end

   // R2
   strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> res_valid);
   // R2
   idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !res_valid);
   // R12
   accept_matches_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_accept == (res_type != 3'd0)));
   // R12
   quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_accept && res_type == 3'd0));
   // R5
   unicast_no_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !da_addr[0]) |=> (res_type != 3'd3 && res_type != 3'd2));
   // R5
   bcast_no_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && &da_addr) |=> (res_type != 3'd3));
   // R9
   promisc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && promisc_seen) |=> (res_type == 3'd4 && res_accept));
   // R10
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_type <= 3'd4);
endmodule

bind rx_addr_filter raf_checker #(.ADDR_W(ADDR_W)) i_raf_checker (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
   .res_valid(res_valid), .res_accept(res_accept), .res_type(res_type)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
   localparam int AW = 6;
   localparam int NS = 2;
   localparam logic [2:0] T_NONE = 3'd0, T_EXACT = 3'd1, T_BCAST = 3'd2,
                          T_HASH = 3'd3, T_PROM = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [15:0]   cfg_wdata = '0;
   logic          da_valid = 1'b0;
   logic [47:0]   da_addr = '0;
   logic          res_valid, res_accept;
   logic [2:0]    res_type;

   int checks = 0;
   int fails  = 0;
   bit timed_out = 1'b0;

   always #5 clk = ~clk;

   rx_addr_filter #(.NUM_SLOTS(NS), .ADDR_W(AW)) i_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
      .res_valid(res_valid), .res_accept(res_accept), .res_type(res_type)
   );

   function automatic logic [5:0] bin_of(input logic [47:0] a);
      logic [31:0] c;
      logic [31:0] r;
      logic [7:0]  b;
      c = 32'hFFFF_FFFF;
      for (int n = 0; n < 6; n++) begin
         b = a[8*n +: 8];
         c = c ^ {24'd0, b};
         for (int j = 0; j < 8; j++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      for (int k = 0; k < 32; k++) r[31-k] = c[k];
      return r[28:23];
   endfunction

   function automatic logic [47:0] mk_addr(input int b, input int j);
      logic [47:0] a;
      a[47:32] = 16'(j * 40503 + b * 11);
      a[31:0]  = 32'(b * 32'h9E37_79B1 + j * 7919 + 12345);
      return a;
   endfunction

   task automatic expect_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ctrl(input bit prom, input bit hen, input logic [1:0] en);
      wr(0, {6'd0, en, 6'd0, hen, prom});
   endtask

   task automatic set_slot(input int s, input logic [47:0] a);
      wr(8 + 3*s,     a[15:0]);
      wr(8 + 3*s + 1, a[31:16]);
      wr(8 + 3*s + 2, a[47:32]);
   endtask

   task automatic set_tbl(input logic [63:0] t);
      for (int w = 0; w < 4; w++) wr(1 + w, t[16*w +: 16]);
   endtask

   // R12 accompanies every lookup check
   task automatic lookup(input string req, input logic [47:0] a, input logic [2:0] exp);
      @(negedge clk);
      da_valid = 1'b1; da_addr = a;
      @(negedge clk);
      da_valid = 1'b0;
      expect_eq(req, int'(res_type), int'(exp));
      expect_eq({req, "/R12"}, int'(res_accept), int'(exp != T_NONE));
      expect_eq({req, "/R2"}, int'(res_valid), 1);
   endtask

   task automatic run();
      logic [47:0] own;
      logic [47:0] mc;
      own = {8'h09, 8'h13, 8'h00, 8'h43, 8'h07, 8'h00};
      repeat (3) @(negedge clk);
      // R1 reset state
      expect_eq("R1 valid", int'(res_valid), 0);
      expect_eq("R1 accept", int'(res_accept), 0);
      expect_eq("R1 type", int'(res_type), 0);
      rst_n = 1'b1;
      lookup("R1 bcast after reset", '1, T_NONE);
      lookup("R1 mcast after reset", 48'h0000_0000_0001, T_NONE);
      @(negedge clk);
      expect_eq("R2 one-cycle pulse", int'(res_valid), 0);

      // R6 exact slot layout and every single-bit miss
      set_slot(0, own);
      ctrl(0, 0, 2'b01);
      lookup("R6 exact hit", own, T_EXACT);
      for (int i = 0; i < 48; i++) lookup("R6 bit miss", own ^ (48'd1 << i), T_NONE);

      // R7 disabled slot
      ctrl(0, 0, 2'b00);
      lookup("R7 disabled slot", own, T_NONE);
      ctrl(0, 0, 2'b10);
      lookup("R7 other slot only", own, T_NONE);

      // R8 broadcast slot
      set_slot(1, '1);
      ctrl(0, 0, 2'b11);
      lookup("R8 bcast", '1, T_BCAST);
      lookup("R6 exact with bcast slot", own, T_EXACT);
      ctrl(0, 0, 2'b01);
      lookup("R8 bcast slot off", '1, T_NONE);

      // R3 sweep of all bins
      ctrl(0, 1, 2'b00);
      for (int b = 0; b < 64; b++) begin
         set_tbl(64'd1 << b);
         for (int j = 0; j < 16; j++) begin
            mc = mk_addr(b, j) | 48'd1;
            lookup("R3 hash bin", mc, (bin_of(mc) == 6'(b)) ? T_HASH : T_NONE);
         end
         mc = mk_addr(b, 99) | 48'd1;
         while (bin_of(mc) != 6'(b)) mc = mc + 48'd2;
         lookup("R3 hash forced hit", mc, T_HASH);
      end

      // R4 hash disabled
      set_tbl('1);
      ctrl(0, 0, 2'b00);
      for (int j = 0; j < 8; j++) lookup("R4 hash off", mk_addr(7, j) | 48'd1, T_NONE);

      // R5 unicast and broadcast never hash
      ctrl(0, 1, 2'b00);
      for (int j = 0; j < 8; j++) lookup("R5 unicast", mk_addr(3, j) & ~48'd1, T_NONE);
      lookup("R5 bcast no hash", '1, T_NONE);
      lookup("R5 mcast hashes", mk_addr(3, 0) | 48'd1, T_HASH);

      // R10 priority
      mc = 48'h0000_5E00_0001 | 48'h0000_0000_0100;
      mc = mc | 48'd1;
      set_slot(0, mc);
      ctrl(0, 1, 2'b11);
      lookup("R10 hash over exact", mc, T_HASH);
      lookup("R10 bcast with table full", '1, T_BCAST);
      ctrl(0, 0, 2'b11);
      lookup("R10 exact when hash off", mc, T_EXACT);
      ctrl(1, 1, 2'b11);
      lookup("R10 promisc over hash", mc, T_PROM);
      lookup("R10 promisc over bcast", '1, T_PROM);

      // R9 promiscuous
      ctrl(1, 0, 2'b00);
      for (int j = 0; j < 8; j++) lookup("R9 promisc", mk_addr(j, j), T_PROM);

      // R11 write in lookup cycle
      ctrl(0, 0, 2'b00);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = '0; cfg_wdata = 16'h0001;
      da_valid = 1'b1; da_addr = 48'h1234_5678_9ABC;
      @(negedge clk);
      cfg_we = 1'b0; da_valid = 1'b0;
      expect_eq("R11 old config used", int'(res_type), int'(T_NONE));
      lookup("R11 new config next", 48'h1234_5678_9ABC, T_PROM);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule